// File: doc/BRIEF.md
# Bank-Interleaved Destination Register Allocator

This block hands out destination physical registers to a dispatch group of up to eight instructions per cycle. The register file is split into four banks, and each bank has its own free list. Lane `i` of the group always draws from bank `i mod 4`. Eight in-order results written at dispatch therefore land two per bank, so each bank needs only two write ports for them.

Each free list is a circular FIFO of slot numbers. It can give out two entries and take back two entries in one cycle. A register index is eight bits: the bank number in bits 7:6 and the slot within the bank in bits 5:0. The allocation is all-or-nothing. If any bank holds fewer free slots than the lanes mapped to it request, the whole group stalls and no bank gives out anything.

Registers released at commit arrive on eight generic free ports. Each one is routed to the bank named in its index field. After reset, slots 0 to 3 of every bank are held back as architectural registers. Slots 4 to 63 of every bank are free.

Top module: `bank_reg_alloc`

## Requirements
- R1: After reset, each bank's free list holds slots 4,5,...,63 in that order. The first group of eight requests gives lane b the index {b,4} and lane b+4 the index {b,5}.
- R2: A register granted to lane l has bank field (bits 7:6) equal to l mod 4. Its slot number is in bits 5:0.
- R3: Within a bank, free slots are handed out oldest first. Among the requesting lanes of one bank, the lower-numbered lane receives the older entry. A lone requesting upper lane receives the head entry.
- R4: `stall` is high in the same cycle exactly when some bank holds fewer free entries than the number of requesting lanes mapped to it. While stalled, no lane is granted and no bank consumes an entry.
- R5: When `stall` is low, `alloc_gnt` equals `alloc_req` in the same cycle. The granted indices are valid on `alloc_preg` in that cycle.
- R6: A register presented on a free port is appended to the tail of the free list of the bank given by its bits 7:6. It can be granted from the next cycle on.
- R7: Up to two frees per bank per cycle are accepted, on any of the eight free ports. They are appended in ascending port order. Frees and grants in the same cycle both take effect. A register freed in a cycle is not available to that same cycle's grants.
- R8: A cycle with no requests never stalls and consumes no entries.
- R9: No two lanes granted in the same cycle receive the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 8 | Per-lane request for a destination register, lane i in bit i |
| alloc_gnt | output | 8 | Per-lane grant, combinational from the requests |
| alloc_preg | output | 64 | Index for lane i in bits [8i+7:8i]: {bank[1:0], slot[5:0]} |
| stall | output | 1 | Group cannot be served this cycle; nothing is taken |
| free_vld | input | 8 | Per-port valid for a register returned at commit |
| free_preg | input | 64 | Freed index for port j in bits [8j+7:8j] |

## Verification
The checks assume that callers free only registers previously granted and not yet freed, and that no bank receives more than two frees in one cycle. A property enforces the second condition. The stimulus keeps to both conditions by drawing every free from a pool of outstanding grants. It takes at most two entries per bank in any cycle, and places them on consecutive free ports so that the order of appends is known. Request patterns cover all 256 lane masks while the free lists run from full through empty and back. This covers the stall, partial-bank and same-cycle free cases.

// File: rtl/pra_pkg.sv
// Package: default configuration of the bank-interleaved allocator.
// Assumes: bank and slot counts are powers of two; lanes divide evenly by banks.
package pra_pkg;
    localparam int unsigned PRA_BANKS      = 4;
    localparam int unsigned PRA_SLOTS      = 64;
    localparam int unsigned PRA_LANES      = 8;
    localparam int unsigned PRA_FREE_PORTS = 8;
    localparam int unsigned PRA_RESERVED   = 4;
    localparam int unsigned PRA_PUSHES     = 2;
endpackage

// File: rtl/pra_free_route.sv
// Module: routes generic free ports to per-bank push slots by the bank field
// of each freed index, keeping ascending port order inside a bank.
// Assumes: at most PUSHES frees target one bank per cycle; extras are dropped.
module pra_free_route #(
    parameter int NB     = 4,
    parameter int FPORTS = 8,
    parameter int PUSHES = 2,
    parameter int SLOT_W = 6,
    parameter int BANK_W = 2,
    localparam int PREG_W = BANK_W + SLOT_W
) (
    input  logic [FPORTS-1:0]           free_vld,
    input  logic [FPORTS*PREG_W-1:0]    free_preg,
    output logic [NB*PUSHES-1:0]        push_vld,
    output logic [NB*PUSHES*SLOT_W-1:0] push_slot
);
    // Purpose: assign each valid free to the next open push slot of its bank.
    always_comb begin
        int n;
        push_vld  = '0;
        push_slot = '0;
        for (int b = 0; b < NB; b++) begin
            n = 0;
            for (int p = 0; p < FPORTS; p++) begin
                if (free_vld[p] && (free_preg[p*PREG_W+SLOT_W +: BANK_W] == BANK_W'(b))
                        && (n < PUSHES)) begin
                    push_vld[b*PUSHES+n]                = 1'b1;
                    push_slot[(b*PUSHES+n)*SLOT_W +: SLOT_W] = free_preg[p*PREG_W +: SLOT_W];
                    n = n + 1;
                end
            end
        end
    end
endmodule

// File: rtl/pra_bank_fl.sv
// Module: one bank's free list, a circular FIFO of slot numbers that gives out
// up to PER_BANK entries and accepts up to PUSHES entries per cycle.
// Assumes: take is only high when enough is high in every bank; pushes never
// exceed the space left (only previously granted slots are returned).
module pra_bank_fl #(
    parameter int SLOTS    = 64,
    parameter int RESV     = 4,
    parameter int PER_BANK = 2,
    parameter int PUSHES   = 2,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int CNT_W   = $clog2(SLOTS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PER_BANK-1:0]        req,
    input  logic                       take,
    input  logic [PUSHES-1:0]          push_vld,
    input  logic [PUSHES*SLOT_W-1:0]   push_slot,
    output logic                       enough,
    output logic [PER_BANK*SLOT_W-1:0] slot_out
);
    logic [SLOT_W-1:0] mem [SLOTS];
    logic [SLOT_W-1:0] head, tail;
    logic [CNT_W-1:0]  count, n_pop, n_push;
    logic [SLOT_W-1:0] push_addr [PUSHES];

    // Purpose: offer head entries to requesting lanes in lane order and count them.
    always_comb begin
        n_pop    = '0;
        slot_out = '0;
        for (int k = 0; k < PER_BANK; k++) begin
            slot_out[k*SLOT_W +: SLOT_W] = mem[head + SLOT_W'(n_pop)];
            if (req[k]) n_pop = n_pop + 1'b1;
        end
        enough = (count >= n_pop);
    end

    // Purpose: give each valid push the next tail position in port order.
    always_comb begin
        n_push = '0;
        for (int j = 0; j < PUSHES; j++) begin
            push_addr[j] = tail + SLOT_W'(n_push);
            if (push_vld[j]) n_push = n_push + 1'b1;
        end
    end

    // Purpose: hold list contents and pointers; reset fills non-reserved slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= SLOT_W'(SLOTS - RESV);
            count <= CNT_W'(SLOTS - RESV);
            for (int k = 0; k < SLOTS; k++) mem[k] <= SLOT_W'(k + RESV);
        end else begin
            for (int j = 0; j < PUSHES; j++)
                if (push_vld[j]) mem[push_addr[j]] <= push_slot[j*SLOT_W +: SLOT_W];
            tail  <= tail + SLOT_W'(n_push);
            if (take) head <= head + SLOT_W'(n_pop);
            count <= count - (take ? n_pop : '0) + n_push;
        end
    end
endmodule

// File: rtl/bank_reg_alloc.sv
// Module: top of the allocator. Lane l draws from bank l mod NB; the group is
// granted only if every bank can serve all its requesting lanes.
// Assumes: LANES is a multiple of NB; frees name registers currently in use.
module bank_reg_alloc #(
    parameter int NB     = pra_pkg::PRA_BANKS,
    parameter int SLOTS  = pra_pkg::PRA_SLOTS,
    parameter int LANES  = pra_pkg::PRA_LANES,
    parameter int FPORTS = pra_pkg::PRA_FREE_PORTS,
    parameter int RESV   = pra_pkg::PRA_RESERVED,
    parameter int PUSHES = pra_pkg::PRA_PUSHES,
    localparam int BANK_W   = $clog2(NB),
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int PREG_W   = BANK_W + SLOT_W,
    localparam int PER_BANK = LANES / NB
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         alloc_req,
    output logic [LANES-1:0]         alloc_gnt,
    output logic [LANES*PREG_W-1:0]  alloc_preg,
    output logic                     stall,
    input  logic [FPORTS-1:0]        free_vld,
    input  logic [FPORTS*PREG_W-1:0] free_preg
);
    logic [NB-1:0]                enough;
    logic                         take;
    logic [NB*PUSHES-1:0]         push_vld;
    logic [NB*PUSHES*SLOT_W-1:0]  push_slot;

    pra_free_route #(
        .NB(NB), .FPORTS(FPORTS), .PUSHES(PUSHES), .SLOT_W(SLOT_W), .BANK_W(BANK_W)
    ) u_route (
        .free_vld (free_vld),
        .free_preg(free_preg),
        .push_vld (push_vld),
        .push_slot(push_slot)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [PER_BANK-1:0]        breq;
        logic [PER_BANK*SLOT_W-1:0] bslot;

        for (genvar k = 0; k < PER_BANK; k++) begin : g_lane
            assign breq[k] = alloc_req[b + k*NB];
            assign alloc_preg[(b + k*NB)*PREG_W +: PREG_W] =
                {BANK_W'(b), bslot[k*SLOT_W +: SLOT_W]};
        end

        pra_bank_fl #(
            .SLOTS(SLOTS), .RESV(RESV), .PER_BANK(PER_BANK), .PUSHES(PUSHES)
        ) u_fl (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (breq),
            .take     (take),
            .push_vld (push_vld[b*PUSHES +: PUSHES]),
            .push_slot(push_slot[b*PUSHES*SLOT_W +: PUSHES*SLOT_W]),
            .enough   (enough[b]),
            .slot_out (bslot)
        );
    end

    // Purpose: all-or-nothing group decision from the per-bank sufficiency flags.
    always_comb begin
        stall     = ~(&enough);
        take      = ~stall;
        alloc_gnt = alloc_req & {LANES{take}};
    end
endmodule

// File: rtl/bank_reg_alloc_chk.sv
// Module: properties over the allocator's ports; attached by bind below.
// Assumes: reset is held for at least one clock before release.
module bank_reg_alloc_chk #(
    parameter int NB     = 4,
    parameter int SLOTS  = 64,
    parameter int LANES  = 8,
    parameter int FPORTS = 8,
    parameter int PUSHES = 2,
    localparam int BANK_W = $clog2(NB),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int PREG_W = BANK_W + SLOT_W,
    localparam int FC_W   = $clog2(FPORTS + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [LANES-1:0]         alloc_req,
    input logic [LANES-1:0]         alloc_gnt,
    input logic [LANES*PREG_W-1:0]  alloc_preg,
    input logic                     stall,
    input logic [FPORTS-1:0]        free_vld,
    input logic [FPORTS*PREG_W-1:0] free_preg
);
    logic            past_ok;
    logic [FC_W-1:0] fcnt [NB];

    // Purpose: mark cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Purpose: count frees aimed at each bank this cycle.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            fcnt[b] = '0;
            for (int p = 0; p < FPORTS; p++)
                if (free_vld[p] && free_preg[p*PREG_W+SLOT_W +: BANK_W] == BANK_W'(b))
                    fcnt[b] = fcnt[b] + 1'b1;
        end
    end

    // R4
    stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (alloc_gnt == '0));

    // R4
    stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(stall) && $stable(alloc_req) && $past(free_vld) == '0) |-> stall);

    // R5
    grant_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |-> (alloc_gnt == alloc_req));

    // R8
    idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req == '0) |-> !stall);

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        // R2
        lane_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_gnt[l] |-> (alloc_preg[l*PREG_W+SLOT_W +: BANK_W] == BANK_W'(l % NB)));
        for (genvar m = l + 1; m < LANES; m++) begin : g_pair
            // R9
            distinct_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (alloc_gnt[l] && alloc_gnt[m]) |->
                (alloc_preg[l*PREG_W +: PREG_W] != alloc_preg[m*PREG_W +: PREG_W]));
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank_chk
        // R7
        free_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fcnt[b] <= FC_W'(PUSHES));
    end
endmodule

bind bank_reg_alloc bank_reg_alloc_chk #(
    .NB(NB), .SLOTS(SLOTS), .LANES(LANES), .FPORTS(FPORTS), .PUSHES(PUSHES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_req (alloc_req),
    .alloc_gnt (alloc_gnt),
    .alloc_preg(alloc_preg),
    .stall     (stall),
    .free_vld  (free_vld),
    .free_preg (free_preg)
);

// File: tb/test_bank_reg_alloc.sv
// Bench: sweeps every request mask while free lists drain and refill; the
// expected indices come from an arithmetic FIFO model per bank.
module test_bank_reg_alloc;
    localparam int NB = 4, SLOTS = 64, LANES = 8, FPORTS = 8, RESV = 4, PUSHES = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  alloc_req, alloc_gnt, free_vld;
    logic [63:0] alloc_preg, free_preg;
    logic        stall;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    int fmem [NB][SLOTS];
    int fh [NB];
    int fc [NB];
    int pool [$];

    always #10 clk = ~clk;

    bank_reg_alloc i_bank_reg_alloc (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
        .alloc_preg(alloc_preg), .stall(stall), .free_vld(free_vld), .free_preg(free_preg)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: pick frees from outstanding grants, drive, check, update model.
    task automatic step(input logic [7:0] req, input int nfree, input int want,
                        input int off, input string tag);
        int nreq [NB];
        int per [NB];
        int pick [$];
        int rest [$];
        int got [$];
        bit st;
        int b, k, e, o;
        @(negedge clk);
        for (int i = 0; i < NB; i++) begin nreq[i] = 0; per[i] = 0; end
        foreach (pool[i]) begin
            b = pool[i] / SLOTS;
            if (pick.size() < nfree && per[b] < PUSHES && (want < 0 || want == b)) begin
                pick.push_back(pool[i]);
                per[b]++;
            end else rest.push_back(pool[i]);
        end
        pool = rest;
        o = (off + pick.size() > FPORTS) ? FPORTS - pick.size() : off;
        free_vld  = '0;
        free_preg = '0;
        foreach (pick[j]) begin
            free_vld[o+j]         = 1'b1;
            free_preg[(o+j)*8 +: 8] = pick[j][7:0];
        end
        alloc_req = req;
        #2;
        for (int l = 0; l < LANES; l++) if (req[l]) nreq[l % NB]++;
        st = 1'b0;
        for (int i = 0; i < NB; i++) if (nreq[i] > fc[i]) st = 1'b1;
        // R4 stall decision, R8 for empty masks
        chk(stall === st, {tag, " R4 stall"}, int'(stall), int'(st));
        // R5 grant mirrors requests when not stalled
        chk(alloc_gnt === (st ? 8'h00 : req), {tag, " R5 grant"},
            int'(alloc_gnt), st ? 0 : int'(req));
        if (!st) begin
            for (int l = 0; l < LANES; l++) begin
                if (req[l]) begin
                    b = l % NB;
                    k = 0;
                    for (int m = b; m < l; m += NB) if (req[m]) k++;
                    e = b * SLOTS + fmem[b][(fh[b] + k) % SLOTS];
                    // R2 bank field, R3 order, R6 R7 returned entries
                    chk(alloc_preg[l*8 +: 8] === e[7:0], {tag, " R2 R3 R6 R7 index"},
                        int'(alloc_preg[l*8 +: 8]), e);
                    got.push_back(int'(alloc_preg[l*8 +: 8]));
                    pool.push_back(e);
                end
            end
            // R9 no duplicate index in one group
            e = 0;
            foreach (got[i]) for (int j = i + 1; j < got.size(); j++) if (got[i] == got[j]) e++;
            chk(e == 0, {tag, " R9 distinct"}, e, 0);
            for (int i = 0; i < NB; i++) begin
                fh[i] = (fh[i] + nreq[i]) % SLOTS;
                fc[i] = fc[i] - nreq[i];
            end
        end
        foreach (pick[j]) begin
            b = pick[j] / SLOTS;
            fmem[b][(fh[b] + fc[b]) % SLOTS] = pick[j] % SLOTS;
            fc[b]++;
        end
    endtask

    initial begin
        rst_n = 1'b0;
        alloc_req = '0;
        free_vld = '0;
        free_preg = '0;
        for (int b = 0; b < NB; b++) begin
            fh[b] = 0;
            fc[b] = SLOTS - RESV;
            for (int k = 0; k < SLOTS; k++) fmem[b][k] = (k + RESV) % SLOTS;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step(8'h00, 0, -1, 0, "R1 R8 idle after reset");
        // R1 first group: lane b gets slot 4, lane b+4 gets slot 5
        step(8'hFF, 0, -1, 0, "R1 first group");
        repeat (31) step(8'hFF, 0, -1, 0, "R4 drain");
        step(8'h01, 0, -1, 0, "R4 empty bank");
        step(8'h00, 1, 2, 3, "R6 single free");
        step(8'h44, 0, -1, 0, "R4 partial bank");
        step(8'h40, 0, -1, 0, "R3 upper lane alone");
        step(8'h04, 2, 2, 5, "R7 free same cycle");
        step(8'h44, 0, -1, 0, "R7 after free");
        for (int p = 0; p < 256; p++)
            step(p[7:0], (p * 5) % 9, -1, p % 8, "R7 sweep a");
        for (int p = 0; p < 256; p++)
            step(~p[7:0], (p * 7 + 3) % 9, -1, (p * 3) % 8, "R3 sweep b");
        step(8'h00, 8, -1, 0, "R8 idle with frees");
        step(8'hFF, 0, -1, 0, "R8 after idle");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R4 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule